// File: doc/BRIEF.md
# Smart card character link controller

This block moves single bytes across the one shared, open-drain data wire of a smart card contact. The wire is pulled high by an external resistor and the block only ever pulls it low or lets it go. It handles one direction at a time. A character is a low start bit, eight data bits with the least significant first, and one even-parity bit. Each bit lasts one elementary time unit (ETU). The ETU length in clock cycles is set by the `etu_div` input, for example 372.

When the block receives a character with bad parity, it pulls the wire low for one ETU as an error signal. It then still hands the byte up, with an error flag set. When the block transmits, it watches for that error signal after each character and sends the same byte again automatically. After a set number of resends it gives up. It then drops the byte and reports a transmit failure.

Bytes to send enter through a valid/ready handshake. Received bytes leave as a one-cycle strobe carrying the data and the parity flag. The wire appears as a drive-low enable output and a sense input.

Top module: `sc_char_link`

## Requirements
- R1: After reset the wire is released (`line_drive_low` = 0), `rx_valid` and `tx_fail` are 0, and `tx_ready` is 1 while the wire reads high.
- R2: A byte accepted by `tx_valid && tx_ready` goes out as follows, each bit lasting `etu_div` cycles, and the wire is released after the parity bit:
  - first a low start bit;
  - then bits 0 to 7 of the byte, least significant first;
  - then a parity bit equal to the XOR of the eight data bits, so the nine bits hold an even number of ones.
- R3: A transmitted start bit never begins less than 12 ETU after the start of the previous character on the wire, whichever side sent that character.
- R4: For a received character with even parity, the block pulses `rx_valid` for one cycle with `rx_data` equal to the byte and `rx_perr` = 0, and it does not drive the wire.
- R5: For a received character with odd parity, the block pulses `rx_valid` with `rx_perr` = 1. It also drives the wire low for exactly `etu_div` cycles, starting half an ETU after the middle of the parity bit.
- R6: When the wire is low half an ETU into the guard time after a transmitted character, the block sends the same byte again without a new handshake.
- R7: Once MAX_RETRY resends (default 3, so 4 sends in all) have all met the error signal, `tx_fail` pulses for one cycle and the byte is dropped. The next queued byte is then sent normally.
- R8: A low pulse on the idle wire that reads high again by mid-bit is ignored. It gives no `rx_valid` and no drive, and the block returns to ready.
- R9: If a synchronized falling edge on the idle wire and `tx_valid` fall in the same cycle, the receive wins. `tx_ready` is 0 in that cycle, the incoming byte is received intact, and the waiting byte is sent after that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_div | input | DIV_W | Clock cycles per ETU (at least 4) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block takes the offered byte this cycle |
| tx_fail | output | 1 | One-cycle pulse: byte dropped after the last retry |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data and rx_perr |
| rx_perr | output | 1 | Received character had odd parity |
| line_drive_low | output | 1 | 1 pulls the data wire low, 0 releases it |
| line_in | input | 1 | Level sensed on the data wire |

## Verification
Start-bit detection and a transmit request can both fall in the same clock cycle. This happens when the card begins a character just as the host offers a byte. The bench provokes it by pulling the wire low on a falling clock edge and raising `tx_valid` two falling edges later, which is exactly the cycle the synchronized edge becomes visible. It judges the outcome on four points: `tx_ready` reads 0 in that cycle, the card's byte arrives intact, no collision corrupts it, and the waiting byte then reaches the card model no earlier than 12 ETU after the card's start bit.

// File: rtl/sc_char_link.sv
module sc_char_link #(
  parameter int DIV_W     = 16,
  parameter int MAX_RETRY = 3,
  parameter int GUARD_ETU = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] etu_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_fail,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_perr,
  output logic             line_drive_low,
  input  logic             line_in
);

  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RX_START, S_RX_BITS, S_RX_WAIT,
    S_RX_ERR, S_RX_GUARD, S_TX_BITS, S_TX_GUARD
  } state_t;

  state_t           st;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       bitn;
  logic [2:0]       sync;
  logic [7:0]       tx_byte;
  logic [7:0]       rx_sh;
  logic [RW-1:0]    retry;
  logic             nak;

  wire line_s   = sync[1];
  wire line_old = sync[2];
  wire etu_end  = (cnt == etu_div - 1'b1);
  wire half_end = (cnt == (etu_div >> 1) - 1'b1);
  wire listen   = (st == S_IDLE) || (st == S_RX_GUARD);
  wire fall     = listen && !line_s && line_old;
  wire [9:0] frame = {^tx_byte, tx_byte, 1'b0};

  assign tx_ready       = (st == S_IDLE) && !fall;
  assign line_drive_low = ((st == S_TX_BITS) && !frame[bitn]) ||
                          ((st == S_RX_ERR) && rx_perr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sync     <= '1;
      tx_byte  <= '0;
      rx_sh    <= '0;
      retry    <= '0;
      nak      <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      tx_fail  <= 1'b0;
    end else begin
      sync     <= {sync[1:0], line_in};
      rx_valid <= 1'b0;
      tx_fail  <= 1'b0;
      cnt      <= etu_end ? '0 : cnt + 1'b1;
      if (fall) begin
        st   <= S_RX_START;
        cnt  <= '0;
        bitn <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            cnt  <= '0;
            bitn <= '0;
            if (tx_valid) begin
              tx_byte <= tx_data;
              retry   <= '0;
              st      <= S_TX_BITS;
            end
          end
          S_RX_START: begin
            if (half_end) begin
              cnt <= '0;
              st  <= line_s ? S_IDLE : S_RX_BITS;
            end
          end
          S_RX_BITS: begin
            if (etu_end) begin
              if (bitn == 4'd8) begin
                rx_data  <= rx_sh;
                rx_perr  <= line_s ^ (^rx_sh);
                rx_valid <= 1'b1;
                st       <= S_RX_WAIT;
              end else begin
                rx_sh <= {line_s, rx_sh[7:1]};
                bitn  <= bitn + 1'b1;
              end
            end
          end
          S_RX_WAIT: begin
            if (half_end) begin
              cnt <= '0;
              st  <= S_RX_ERR;
            end
          end
          S_RX_ERR: begin
            if (etu_end) begin
              bitn <= '0;
              st   <= S_RX_GUARD;
            end
          end
          S_RX_GUARD: begin
            if (etu_end) begin
              if (bitn == 4'(GUARD_ETU - 2)) st <= S_IDLE;
              else bitn <= bitn + 1'b1;
            end
          end
          S_TX_BITS: begin
            if (etu_end) begin
              if (bitn == 4'd9) begin
                bitn <= '0;
                nak  <= 1'b0;
                st   <= S_TX_GUARD;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          end
          S_TX_GUARD: begin
            if (bitn == 4'd0 && half_end && !line_s) nak <= 1'b1;
            if (etu_end) begin
              if (bitn == 4'(GUARD_ETU - 1)) begin
                bitn <= '0;
                if (!nak) begin
                  st <= S_IDLE;
                end else if (retry == RW'(MAX_RETRY)) begin
                  tx_fail <= 1'b1;
                  st      <= S_IDLE;
                end else begin
                  retry <= retry + 1'b1;
                  st    <= S_TX_BITS;
                end
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_ready_means_released: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !line_drive_low);

  a_r2_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (line_drive_low && !tx_ready));

  a_r2_release_after_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX_BITS && bitn == 4'd9 && etu_end) |=> !line_drive_low);

  a_r4_rx_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r4_quiet_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX_BITS || st == S_RX_START) |-> !line_drive_low);

  a_r5_pulse_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_drive_low) && st == S_RX_ERR) |-> rx_perr);

  a_r7_fail_only_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |-> (retry == RW'(MAX_RETRY) && st == S_IDLE));

  a_r8_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX_START && half_end && line_s) |=> (st == S_IDLE && !rx_valid));

  a_r9_receive_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && fall && tx_valid) |=> (st == S_RX_START && !line_drive_low));

endmodule

// File: tb/sc_char_link_tb.sv
`timescale 1ns/1ps
module sc_char_link_tb_top;
  localparam int E = 16;
  localparam int MAXR = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] etu_div = 16'(E);
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_fail, rx_valid, rx_perr, line_drive_low;
  logic [7:0]  rx_data;
  logic        card_low = 1'b0;
  logic        card_listen = 1'b1;
  wire         line = ~(line_drive_low | card_low);

  int checks = 0, errors = 0, cyc = 0, cs_cyc = 0;
  int c_n = 0, r_n = 0, fail_n = 0, drive_cnt = 0, nak_budget = 0;
  logic [7:0] c_byte [64];
  bit         c_par_ok [64];
  int         c_start [64];
  logic [7:0] r_data;
  bit         r_perr;
  bit         done = 1'b0;

  sc_char_link #(.DIV_W(16), .MAX_RETRY(MAXR), .GUARD_ETU(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .etu_div(etu_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_fail(tx_fail),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
    .line_drive_low(line_drive_low), .line_in(line));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit even_par(input logic [7:0] b);
    return ^b;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin r_data = rx_data; r_perr = rx_perr; r_n++; end
    if (rst_n && tx_fail) fail_n++;
    if (rst_n && line_drive_low) drive_cnt++;
  end

  initial begin
    logic [8:0] bits;
    bit nk;
    int t0;
    forever begin
      @(negedge clk);
      if (rst_n && card_listen && !card_low && line === 1'b0) begin
        t0 = cyc;
        repeat (E/2) @(negedge clk);
        for (int i = 0; i < 9; i++) begin repeat (E) @(negedge clk); bits[i] = line; end
        c_byte[c_n & 63] = bits[7:0];
        c_par_ok[c_n & 63] = (^bits) == 1'b0;
        c_start[c_n & 63] = t0;
        c_n++;
        nk = (nak_budget > 0) || (^bits);
        if (nak_budget > 0) nak_budget--;
        repeat (E/2) @(negedge clk);
        if (nk) begin card_low = 1'b1; repeat (E) @(negedge clk); card_low = 1'b0; end
      end
    end
  end

  task automatic send_card(input logic [7:0] b, input bit bad, output bit saw, output int plen);
    logic [9:0] f;
    card_listen = 1'b0;
    cs_cyc = cyc;
    f = {even_par(b) ^ bad, b, 1'b0};
    for (int i = 0; i < 10; i++) begin card_low = ~f[i]; repeat (E) @(negedge clk); end
    card_low = 1'b0;
    plen = 0;
    for (int k = 0; k < 2*E; k++) begin @(negedge clk); if (line == 1'b0) plen++; end
    saw = plen > 0;
    card_listen = 1'b1;
  endtask

  task automatic dut_send(input logic [7:0] b);
    tx_data = b;
    tx_valid = 1'b1;
    while (tx_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_case(input logic [7:0] b, input int naks, input string req);
    int n0, f0;
    n0 = c_n; f0 = fail_n;
    nak_budget = naks;
    dut_send(b);
    repeat ((naks + 1) * 13 * E) @(negedge clk);
    check(c_n == n0 + naks + 1, req, "sends seen", c_n - n0, naks + 1);
    for (int i = 0; i <= naks; i++) begin
      check(c_byte[(n0 + i) & 63] == b, req, "byte on wire", c_byte[(n0 + i) & 63], b);
      check(c_par_ok[(n0 + i) & 63], "R2", "even parity bit", 0, 1);
    end
    check(fail_n == f0, req, "no tx_fail", fail_n - f0, 0);
  endtask

  task automatic rx_case(input logic [7:0] b, input bit bad);
    int r0, pl;
    bit nk;
    r0 = r_n;
    send_card(b, bad, nk, pl);
    check(r_n == r0 + 1, "R4", "rx strobes", r_n - r0, 1);
    check(r_data == b, "R4", "rx_data", r_data, b);
    check(r_perr == bad, bad ? "R5" : "R4", "rx_perr", r_perr, bad);
    check(pl == (bad ? E : 0), bad ? "R5" : "R4", "error pulse cycles", pl, bad ? E : 0);
  endtask

  initial begin
    int n0, f0, r0, d0, pl;
    bit nk;
    logic [7:0] b;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check(line_drive_low == 1'b0, "R1", "drive in reset", line_drive_low, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
    check(rx_valid == 1'b0 && tx_fail == 1'b0 && line_drive_low == 1'b0, "R1", "quiet outputs",
          {rx_valid, tx_fail, line_drive_low}, 0);

    tx_case(8'hA5, 0, "R2");
    tx_case(8'h00, 0, "R2");
    tx_case(8'hFF, 0, "R2");
    tx_case(8'h01, 0, "R2");
    for (int i = 0; i < 8; i++) tx_case(8'($urandom), 0, "R2");

    n0 = c_n;
    dut_send(8'h11); dut_send(8'h22); dut_send(8'h33);
    repeat (14 * E) @(negedge clk);
    check(c_n == n0 + 3, "R3", "back-to-back count", c_n - n0, 3);
    for (int i = 1; i < 3; i++)
      check(c_start[(n0 + i) & 63] - c_start[(n0 + i - 1) & 63] >= 12 * E, "R3", "start spacing",
            c_start[(n0 + i) & 63] - c_start[(n0 + i - 1) & 63], 12 * E);
    check(c_byte[(n0 + 2) & 63] == 8'h33, "R3", "last back-to-back byte", c_byte[(n0 + 2) & 63], 8'h33);

    rx_case(8'h5A, 1'b0);
    rx_case(8'hC3, 1'b1);
    for (int i = 0; i < 14; i++) rx_case(8'($urandom), ($urandom % 4) == 0);
    repeat (2 * E) @(negedge clk);

    tx_case(8'h3C, 1, "R6");
    for (int i = 0; i < 4; i++) tx_case(8'($urandom), int'($urandom % 3), "R6");

    n0 = c_n; f0 = fail_n;
    nak_budget = MAXR + 1;
    dut_send(8'h96);
    repeat ((MAXR + 2) * 13 * E) @(negedge clk);
    check(c_n == n0 + MAXR + 1, "R7", "sends before giving up", c_n - n0, MAXR + 1);
    check(fail_n == f0 + 1, "R7", "tx_fail pulses", fail_n - f0, 1);
    check(c_byte[(n0 + MAXR) & 63] == 8'h96, "R7", "last resend byte", c_byte[(n0 + MAXR) & 63], 8'h96);
    tx_case(8'h69, 0, "R7");

    for (int g = 1; g <= 5; g += 4) begin
      card_listen = 1'b0;
      r0 = r_n; d0 = drive_cnt;
      card_low = 1'b1;
      repeat (g) @(negedge clk);
      card_low = 1'b0;
      repeat (13 * E) @(negedge clk);
      card_listen = 1'b1;
      check(r_n == r0, "R8", "no strobe from glitch", r_n - r0, 0);
      check(drive_cnt == d0, "R8", "no drive from glitch", drive_cnt - d0, 0);
      check(tx_ready == 1'b1, "R8", "ready after glitch", tx_ready, 1);
    end
    tx_case(8'hE7, 0, "R8");

    for (int k = 0; k < 3; k++) begin
      n0 = c_n; r0 = r_n;
      b = 8'($urandom);
      fork
        send_card(b, 1'b0, nk, pl);
        begin
          repeat (2) @(negedge clk);
          tx_data = 8'h4B + 8'(k);
          tx_valid = 1'b1;
          check(tx_ready == 1'b0, "R9", "tx_ready in edge cycle", tx_ready, 0);
          while (tx_ready !== 1'b1) @(negedge clk);
          @(negedge clk);
          tx_valid = 1'b0;
        end
      join
      repeat (13 * E) @(negedge clk);
      check(r_n == r0 + 1 && r_data == b && !r_perr, "R9", "card byte intact", r_data, b);
      check(c_n == n0 + 1 && c_byte[n0 & 63] == 8'h4B + 8'(k), "R9", "queued byte sent",
            c_byte[n0 & 63], 8'h4B + 8'(k));
      check(c_start[n0 & 63] - cs_cyc >= 12 * E, "R3", "spacing after received char",
            c_start[n0 & 63] - cs_cyc, 12 * E);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all act=%0d exp=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule